// File: doc/BRIEF.md
# Descriptor Accelerator Control and Status Block

This block is the host-facing register file and run sequencer of a crypto accelerator that works through chains of descriptors in memory. Software programs a control word, then writes the address of the first descriptor. That write launches the descriptor engine. The block follows the job through busy, complete, error and hardware-fault states. It records the engine's progress and any error it reports, and it raises one level interrupt when the job ends.

A 32-bit bus with single-cycle write and read strobes reaches every register. Reads return data one cycle after the strobe. The command register acts on write only. It offers a soft reset, separate clear-interrupt and clear-error actions, a single-step request and mode selection. A start address written while a job is running waits in a single pending slot and launches once the block is idle again.

Top module: `accel_csr_top`

## Requirements
- R1: After a hard reset, and on the cycle after a command write with bit 0 set, status, control, error status, fault address, both descriptor address registers, mode and the pending slot all read 0, and the interrupt is low.
- R2: Writing the descriptor address register (offset 0x04) while idle with an empty slot pulses `eng_start` for one cycle after the write edge. `eng_desc_addr` carries the written value, and the initial (0x20) and current (0x1C) address registers both load it.
- R3: While busy, each `eng_cur_vld` cycle loads `eng_cur_addr` into the current address register.
- R4: Status bits 2:0 hold the run state: 0 idle, 1 busy, 2 error, 3 fault, 4 complete. In busy, the engine inputs are ranked fault, then error, then done. In any other state those inputs are ignored.
- R5: On an accepted error, the error status register (0x14) takes the source in bits 3:0. For source 15 it also takes direction in bit 8, size in bits 10:9 and cause in bits 15:13. For source 14 it also takes the one-hot unit cause in bits 27:16 and the unit id in bits 29:28. All other bits read 0. The fault address register (0x18) captures `eng_bad_addr`, and status bit 4 is set.
- R6: The fault state is left only by a soft or hard reset.
- R7: `irq` is high exactly while control bit 4 is set and the state is complete, error or fault. It is never high while busy.
- R8: Command bit 8 alone returns complete to idle. Error returns to idle only when bits 8 and 9 are written together. Bit 9 clears the error status register, the fault address and status bit 4.
- R9: A start address written while not idle goes into the pending slot and sets status bit 3. A write while the slot is full is dropped and sets status bit 4. A pending address launches one cycle after the block returns to idle.
- R10: The control register (0x08) keeps bits 31:16, 7 and 4 and reads 0 in every other bit.
- R11: Command bit 16 selects batch mode and bit 18 selects debug mode; status bits 16 and 18 show the selection. A write with both bits set leaves the mode unchanged. Command bit 10 pulses `eng_step` only in debug mode.
- R12: The version register (0x00) returns the VERSION parameter and ignores writes. Unmapped offsets read 0. Status bits 11:9 mirror `unit_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_desc_addr | output | 32 | First descriptor address of the launched job |
| eng_step | output | 1 | Single-step pulse (debug mode) |
| eng_done | input | 1 | Engine finished the chain |
| eng_err | input | 1 | Engine reports an error |
| eng_fault | input | 1 | Engine reports a hardware fault |
| eng_err_src | input | 4 | Error source code |
| eng_dma_dir | input | 1 | DMA direction, 1 = read |
| eng_dma_size | input | 2 | DMA transfer size |
| eng_dma_cause | input | 3 | DMA error cause |
| eng_unit_cause | input | 12 | One-hot cipher-unit error cause |
| eng_unit_id | input | 2 | Failing unit: 1 cipher, 2 hash, 3 RNG |
| eng_bad_addr | input | 32 | Bus address that failed |
| eng_cur_vld | input | 1 | Current descriptor address update |
| eng_cur_addr | input | 32 | Current descriptor address |
| unit_busy | input | 3 | RNG, hash, cipher activity flags |

## Verification
The bench targets the pending slot. It fills the slot, overflows it, then clears. A design that launched the overflowing address, or forgot the queued one, would show the wrong initial address or no start pulse.

It also drives garbage on the unused error fields for both DMA and unit errors. A capture that did not mask by source would leak those bits into the error status.

The split clear commands are driven one at a time from the error state. A design that left error on clear-interrupt alone, or let clear-error change the state, would read back the wrong state.

A fault is followed by a clear attempt. A design that let that clear leave the fault state would return to idle instead of staying in fault.

// File: rtl/accel_csr_pkg.sv
package accel_csr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NREG   = 9;

  localparam int unsigned OFS_VER   = 'h00;
  localparam int unsigned OFS_DAR   = 'h04;
  localparam int unsigned OFS_CTRL  = 'h08;
  localparam int unsigned OFS_CMD   = 'h0C;
  localparam int unsigned OFS_STAT  = 'h10;
  localparam int unsigned OFS_ERR   = 'h14;
  localparam int unsigned OFS_FADDR = 'h18;
  localparam int unsigned OFS_CUR   = 'h1C;
  localparam int unsigned OFS_INIT  = 'h20;

  localparam int unsigned CMD_SRST  = 0;
  localparam int unsigned CMD_CLRI  = 8;
  localparam int unsigned CMD_CLRE  = 9;
  localparam int unsigned CMD_STEP  = 10;
  localparam int unsigned CMD_BATCH = 16;
  localparam int unsigned CMD_DEBUG = 18;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'hFFFF_0090;
  localparam int unsigned CTRL_IEN = 4;

  localparam logic [3:0] SRC_UNIT = 4'd14;
  localparam logic [3:0] SRC_DMA  = 4'd15;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BUSY  = 3'd1,
    ST_ERR   = 3'd2,
    ST_FAULT = 3'd3,
    ST_DONE  = 3'd4
  } run_state_e;

  function automatic logic [DATA_W-1:0] pack_err(
    input logic [3:0]  src,
    input logic        dir,
    input logic [1:0]  sz,
    input logic [2:0]  dcause,
    input logic [11:0] ucause,
    input logic [1:0]  unit
  );
    logic [DATA_W-1:0] w;
    w = '0;
    w[3:0] = src;
    if (src == SRC_DMA) begin
      w[8]     = dir;
      w[10:9]  = sz;
      w[15:13] = dcause;
    end else if (src == SRC_UNIT) begin
      w[27:16] = ucause;
      w[29:28] = unit;
    end
    return w;
  endfunction
endpackage

// File: rtl/accel_cmd_dec.sv
module accel_cmd_dec import accel_csr_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              dar_wr,
  output logic              ctrl_wr,
  output logic              soft_rst,
  output logic              clr_int,
  output logic              clr_err,
  output logic              step_req,
  output logic              want_batch,
  output logic              want_debug
);
  logic [NREG-1:0] hit;
  logic            cmd_wr;

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign hit[g] = wr_en && (addr == ADDR_W'(g * 4));
  end

  assign dar_wr     = hit[OFS_DAR / 4];
  assign ctrl_wr    = hit[OFS_CTRL / 4];
  assign cmd_wr     = hit[OFS_CMD / 4];
  assign soft_rst   = cmd_wr && wdata[CMD_SRST];
  assign clr_int    = cmd_wr && wdata[CMD_CLRI];
  assign clr_err    = cmd_wr && wdata[CMD_CLRE];
  assign step_req   = cmd_wr && wdata[CMD_STEP];
  assign want_batch = cmd_wr && wdata[CMD_BATCH] && !wdata[CMD_DEBUG];
  assign want_debug = cmd_wr && wdata[CMD_DEBUG] && !wdata[CMD_BATCH];
endmodule

// File: rtl/accel_seq.sv
module accel_seq import accel_csr_pkg::*; #(
  parameter int unsigned DA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_rst,
  input  logic            dar_wr,
  input  logic [DA_W-1:0] dar_val,
  input  logic            clr_int,
  input  logic            clr_err,
  input  logic            eng_done,
  input  logic            eng_err,
  input  logic            eng_fault,
  input  logic            cur_vld,
  input  logic [DA_W-1:0] cur_addr,
  output run_state_e      state_q,
  output run_state_e      state_d,
  output logic            full_q,
  output logic            ovf,
  output logic            err_take,
  output logic            start_q,
  output logic [DA_W-1:0] init_q,
  output logic [DA_W-1:0] curr_q
);
  logic [DA_W-1:0] pend_q;
  logic [DA_W-1:0] launch_addr;
  logic            launch, pend_take, pend_load;

  always_comb begin
    state_d     = state_q;
    launch      = 1'b0;
    launch_addr = dar_val;
    pend_take   = 1'b0;
    pend_load   = 1'b0;
    ovf         = 1'b0;
    err_take    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (full_q) begin
          launch      = 1'b1;
          launch_addr = pend_q;
          pend_take   = 1'b1;
        end else if (dar_wr) begin
          launch = 1'b1;
        end
      end
      ST_BUSY: begin
        if (eng_fault) state_d = ST_FAULT;
        else if (eng_err) begin
          state_d  = ST_ERR;
          err_take = 1'b1;
        end else if (eng_done) state_d = ST_DONE;
      end
      ST_DONE: if (clr_int) state_d = ST_IDLE;
      ST_ERR:  if (clr_int && clr_err) state_d = ST_IDLE;
      default: ;
    endcase
    if (launch) state_d = ST_BUSY;
    if (dar_wr && !(state_q == ST_IDLE && !full_q)) begin
      if (full_q && !pend_take) ovf = 1'b1;
      else pend_load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      full_q  <= 1'b0;
      pend_q  <= '0;
      init_q  <= '0;
      curr_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= launch;
      full_q  <= (full_q && !pend_take) || pend_load;
      if (pend_load) pend_q <= dar_val;
      if (launch) begin
        init_q <= launch_addr;
        curr_q <= launch_addr;
      end else if (state_q == ST_BUSY && cur_vld) begin
        curr_q <= cur_addr;
      end
    end
  end

  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    start_q |-> state_q == ST_BUSY);
  a_r9_ovf_keeps_slot: assert property (@(posedge clk) disable iff (rst)
    (ovf && !soft_rst) |=> ($stable(pend_q) && full_q));
  a_r1_soft_idle: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (state_q == ST_IDLE && !full_q && !start_q));
  a_r6_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FAULT && !soft_rst) |=> state_q == ST_FAULT);
  a_r4_done_rank: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && eng_done && !eng_err && !eng_fault && !soft_rst)
      |=> state_q == ST_DONE);
endmodule

// File: rtl/accel_errcap.sv
module accel_errcap import accel_csr_pkg::*; #(
  parameter int unsigned BA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              capture,
  input  logic              ovf,
  input  logic              clr_err,
  input  logic [3:0]        src,
  input  logic              dir,
  input  logic [1:0]        sz,
  input  logic [2:0]        dcause,
  input  logic [11:0]       ucause,
  input  logic [1:0]        unit,
  input  logic [BA_W-1:0]   bad_addr,
  output logic [DATA_W-1:0] errstat_q,
  output logic [BA_W-1:0]   faddr_q,
  output logic              flag_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      errstat_q <= '0;
      faddr_q   <= '0;
      flag_q    <= 1'b0;
    end else if (capture) begin
      errstat_q <= pack_err(src, dir, sz, dcause, ucause, unit);
      faddr_q   <= bad_addr;
      flag_q    <= 1'b1;
    end else begin
      if (clr_err) begin
        errstat_q <= '0;
        faddr_q   <= '0;
        flag_q    <= 1'b0;
      end
      if (ovf) flag_q <= 1'b1;
    end
  end

  a_r5_dma_masks_unit: assert property (@(posedge clk) disable iff (rst)
    (capture && !soft_rst && src == SRC_DMA) |=> (errstat_q[29:16] == '0 && flag_q));
  a_r5_unit_masks_dma: assert property (@(posedge clk) disable iff (rst)
    (capture && !soft_rst && src == SRC_UNIT) |=> errstat_q[15:4] == '0);
  a_r8_clear_err: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !capture && !ovf) |=> (errstat_q == '0 && !flag_q));
endmodule

// File: rtl/accel_csr_top.sv
module accel_csr_top import accel_csr_pkg::*; #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DA_W    = 32,
  parameter logic [31:0] VERSION = 32'h0004_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic [31:0]       eng_desc_addr,
  output logic              eng_step,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_fault,
  input  logic [3:0]        eng_err_src,
  input  logic              eng_dma_dir,
  input  logic [1:0]        eng_dma_size,
  input  logic [2:0]        eng_dma_cause,
  input  logic [11:0]       eng_unit_cause,
  input  logic [1:0]        eng_unit_id,
  input  logic [31:0]       eng_bad_addr,
  input  logic              eng_cur_vld,
  input  logic [31:0]       eng_cur_addr,
  input  logic [2:0]        unit_busy
);
  logic dar_wr, ctrl_wr, soft_rst, clr_int, clr_err, step_req, want_batch, want_debug;
  run_state_e state_q, state_d;
  logic full_q, ovf, err_take, start_q, err_flag;
  logic [DA_W-1:0] init_q, curr_q;
  logic [DATA_W-1:0] errstat_q, faddr_q, ctrl_q, status_w, rdata_q;
  logic batch_q, debug_q, step_q, irq_q, ien_d;

  accel_cmd_dec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .dar_wr(dar_wr), .ctrl_wr(ctrl_wr), .soft_rst(soft_rst),
    .clr_int(clr_int), .clr_err(clr_err), .step_req(step_req),
    .want_batch(want_batch), .want_debug(want_debug)
  );

  accel_seq #(.DA_W(DA_W)) u_seq (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .dar_wr(dar_wr), .dar_val(bus_wdata[DA_W-1:0]),
    .clr_int(clr_int), .clr_err(clr_err),
    .eng_done(eng_done), .eng_err(eng_err), .eng_fault(eng_fault),
    .cur_vld(eng_cur_vld), .cur_addr(eng_cur_addr[DA_W-1:0]),
    .state_q(state_q), .state_d(state_d), .full_q(full_q), .ovf(ovf),
    .err_take(err_take), .start_q(start_q), .init_q(init_q), .curr_q(curr_q)
  );

  accel_errcap #(.BA_W(DATA_W)) u_err (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .capture(err_take), .ovf(ovf), .clr_err(clr_err),
    .src(eng_err_src), .dir(eng_dma_dir), .sz(eng_dma_size),
    .dcause(eng_dma_cause), .ucause(eng_unit_cause), .unit(eng_unit_id),
    .bad_addr(eng_bad_addr),
    .errstat_q(errstat_q), .faddr_q(faddr_q), .flag_q(err_flag)
  );

  assign ien_d = ctrl_wr ? bus_wdata[CTRL_IEN] : ctrl_q[CTRL_IEN];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_q  <= '0;
      batch_q <= 1'b0;
      debug_q <= 1'b0;
      step_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (want_batch) begin
        batch_q <= 1'b1;
        debug_q <= 1'b0;
      end else if (want_debug) begin
        batch_q <= 1'b0;
        debug_q <= 1'b1;
      end
      step_q <= step_req && debug_q;
      irq_q  <= ien_d && (state_d == ST_DONE || state_d == ST_ERR || state_d == ST_FAULT);
    end
  end

  always_comb begin
    status_w        = '0;
    status_w[2:0]   = state_q;
    status_w[3]     = full_q;
    status_w[4]     = err_flag;
    status_w[11:9]  = unit_busy;
    status_w[16]    = batch_q;
    status_w[18]    = debug_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFS_VER):   rdata_q <= VERSION;
        ADDR_W'(OFS_DAR):   rdata_q <= DATA_W'(init_q);
        ADDR_W'(OFS_CTRL):  rdata_q <= ctrl_q;
        ADDR_W'(OFS_STAT):  rdata_q <= status_w;
        ADDR_W'(OFS_ERR):   rdata_q <= errstat_q;
        ADDR_W'(OFS_FADDR): rdata_q <= faddr_q;
        ADDR_W'(OFS_CUR):   rdata_q <= DATA_W'(curr_q);
        ADDR_W'(OFS_INIT):  rdata_q <= DATA_W'(init_q);
        default:            rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata     = rdata_q;
  assign irq           = irq_q;
  assign eng_start     = start_q;
  assign eng_desc_addr = 32'(init_q);
  assign eng_step      = step_q;

  a_r7_quiet_busy: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_BUSY |-> !irq_q);
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_IDLE |-> !irq_q);
  a_r11_mode_excl: assert property (@(posedge clk) disable iff (rst)
    $countones({batch_q, debug_q}) <= 1);
  a_r11_step_debug: assert property (@(posedge clk) disable iff (rst)
    step_q |-> $past(debug_q));
endmodule

// File: tb/accel_csr_top_tb_top.sv
module accel_csr_top_tb_top;
  localparam logic [31:0] VER = 32'h0004_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, eng_start, eng_step;
  logic [31:0] eng_desc_addr;
  logic eng_done = 0, eng_err = 0, eng_fault = 0, eng_dma_dir = 0, eng_cur_vld = 0;
  logic [3:0] eng_err_src = '0;
  logic [1:0] eng_dma_size = '0, eng_unit_id = '0;
  logic [2:0] eng_dma_cause = '0, unit_busy = '0;
  logic [11:0] eng_unit_cause = '0;
  logic [31:0] eng_bad_addr = '0, eng_cur_addr = '0;

  int n_run = 0, n_fail = 0;
  logic finished = 0;

  always #4 clk = ~clk;

  accel_csr_top #(.VERSION(VER)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_start(eng_start),
    .eng_desc_addr(eng_desc_addr), .eng_step(eng_step), .eng_done(eng_done),
    .eng_err(eng_err), .eng_fault(eng_fault), .eng_err_src(eng_err_src),
    .eng_dma_dir(eng_dma_dir), .eng_dma_size(eng_dma_size), .eng_dma_cause(eng_dma_cause),
    .eng_unit_cause(eng_unit_cause), .eng_unit_id(eng_unit_id), .eng_bad_addr(eng_bad_addr),
    .eng_cur_vld(eng_cur_vld), .eng_cur_addr(eng_cur_addr), .unit_busy(unit_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic pulse_err(input logic [3:0] src, input logic dir, input logic [1:0] sz,
                           input logic [2:0] dc, input logic [11:0] uc, input logic [1:0] un,
                           input logic [31:0] ba);
    @(negedge clk);
    eng_err = 1; eng_err_src = src; eng_dma_dir = dir; eng_dma_size = sz;
    eng_dma_cause = dc; eng_unit_cause = uc; eng_unit_id = un; eng_bad_addr = ba;
    @(negedge clk);
    eng_err = 0;
  endtask

  task automatic t_reset();
    rchk("R1 status after reset", 8'h10, 32'h0);
    rchk("R1 control after reset", 8'h08, 32'h0);
    rchk("R12 version", 8'h00, VER);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map();
    wr(8'h00, 32'h1234_5678);
    rchk("R12 version ignores write", 8'h00, VER);
    rchk("R12 unmapped reads zero", 8'h40, 32'h0);
    unit_busy = 3'b100;
    rchk("R12 unit busy mirror", 8'h10, 32'h0000_0800);
    unit_busy = 3'b000;
    wr(8'h08, 32'hFFFF_FFFF);
    rchk("R10 control mask", 8'h08, 32'hFFFF_0090);
    wr(8'h08, 32'h0000_0010);
  endtask

  task automatic t_launch();
    pulse_done();
    rchk("R4 done ignored idle", 8'h10, 32'h0);
    wr(8'h04, 32'h0000_1000);
    chk("R2 start pulse", {31'b0, eng_start}, 32'h1);
    chk("R2 desc addr", eng_desc_addr, 32'h0000_1000);
    @(negedge clk);
    chk("R2 start one cycle", {31'b0, eng_start}, 32'h0);
    rchk("R2 initial addr", 8'h20, 32'h0000_1000);
    rchk("R2 current addr", 8'h1C, 32'h0000_1000);
    rchk("R4 busy state", 8'h10, 32'h1);
    chk("R7 no irq busy", {31'b0, irq}, 32'h0);
    @(negedge clk); eng_cur_vld = 1; eng_cur_addr = 32'h0000_1040;
    @(negedge clk); eng_cur_vld = 0;
    rchk("R3 current tracks", 8'h1C, 32'h0000_1040);
    pulse_done();
    chk("R7 irq on complete", {31'b0, irq}, 32'h1);
    rchk("R4 complete state", 8'h10, 32'h4);
    wr(8'h0C, 32'h0000_0300);
    chk("R7 irq dropped", {31'b0, irq}, 32'h0);
    rchk("R8 idle after clear", 8'h10, 32'h0);
  endtask

  task automatic t_pending();
    wr(8'h04, 32'h0000_0100);
    wr(8'h04, 32'h0000_0200);
    rchk("R9 full flag", 8'h10, 32'h9);
    wr(8'h04, 32'h0000_0300);
    rchk("R9 overflow error flag", 8'h10, 32'h19);
    pulse_done();
    rchk("R4 complete with full", 8'h10, 32'h1C);
    wr(8'h0C, 32'h0000_0300);
    @(negedge clk);
    chk("R9 pending launch", {31'b0, eng_start}, 32'h1);
    chk("R9 pending addr", eng_desc_addr, 32'h0000_0200);
    rchk("R9 slot empty busy", 8'h10, 32'h1);
    pulse_done();
    wr(8'h0C, 32'h0000_0100);
    rchk("R8 clear int leaves complete", 8'h10, 32'h0);
  endtask

  task automatic t_dma_err();
    wr(8'h04, 32'h0000_0400);
    pulse_err(4'd15, 1'b1, 2'd2, 3'd4, 12'hFFF, 2'd3, 32'h000D_EAD0);
    rchk("R5 dma error status", 8'h14, 32'h0000_850F);
    rchk("R5 fault addr", 8'h18, 32'h000D_EAD0);
    rchk("R5 error state flag", 8'h10, 32'h12);
    chk("R7 irq on error", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h0000_0100);
    rchk("R8 clear int alone keeps error", 8'h10, 32'h12);
    wr(8'h0C, 32'h0000_0200);
    rchk("R8 clear err wipes status", 8'h14, 32'h0);
    rchk("R8 clear err keeps state", 8'h10, 32'h2);
    wr(8'h0C, 32'h0000_0300);
    rchk("R8 both clear to idle", 8'h10, 32'h0);
    chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
    pulse_err(4'd15, 1'b1, 2'd1, 3'd1, 12'h0, 2'd0, 32'h1);
    rchk("R4 error ignored idle", 8'h14, 32'h0);
  endtask

  task automatic t_unit_err();
    wr(8'h04, 32'h0000_0500);
    pulse_err(4'd14, 1'b1, 2'd3, 3'd7, 12'h008, 2'd1, 32'h0000_0ABC);
    rchk("R5 unit error status", 8'h14, 32'h1008_000E);
    wr(8'h0C, 32'h0000_0300);
  endtask

  task automatic t_fault();
    wr(8'h04, 32'h0000_0600);
    @(negedge clk); eng_fault = 1; eng_err = 1; eng_err_src = 4'd15;
    @(negedge clk); eng_fault = 0; eng_err = 0;
    rchk("R4 fault outranks error", 8'h10, 32'h3);
    rchk("R4 fault no capture", 8'h14, 32'h0);
    chk("R7 irq on fault", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h0000_0300);
    rchk("R6 clear keeps fault", 8'h10, 32'h3);
    wr(8'h0C, 32'h0000_0001);
    rchk("R6 soft reset leaves fault", 8'h10, 32'h0);
    chk("R1 irq after soft reset", {31'b0, irq}, 32'h0);
    rchk("R1 control after soft reset", 8'h08, 32'h0);
    rchk("R1 initial after soft reset", 8'h20, 32'h0);
    rchk("R12 version after soft reset", 8'h00, VER);
  endtask

  task automatic t_no_ien();
    wr(8'h04, 32'h0000_0700);
    pulse_done();
    rchk("R7 complete no enable", 8'h10, 32'h4);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h0000_0100);
  endtask

  task automatic t_mode();
    wr(8'h0C, 32'h0001_0000);
    rchk("R11 batch mode", 8'h10, 32'h0001_0000);
    wr(8'h0C, 32'h0000_0400);
    chk("R11 no step in batch", {31'b0, eng_step}, 32'h0);
    wr(8'h0C, 32'h0005_0000);
    rchk("R11 both bits ignored", 8'h10, 32'h0001_0000);
    wr(8'h0C, 32'h0004_0000);
    rchk("R11 debug mode", 8'h10, 32'h0004_0000);
    wr(8'h0C, 32'h0000_0400);
    chk("R11 step in debug", {31'b0, eng_step}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_map();
    t_launch();
    t_pending();
    t_dma_err();
    t_unit_err();
    t_fault();
    t_no_ien();
    t_mode();
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule